// File: doc/BRIEF.md
# Programmable Block Write-Protect Unit

This unit guards a byte-addressed non-volatile array of 8 K bytes. The array is split into sixteen equal blocks of 512 bytes each. The unit listens to the address bytes of each incoming write command. Most commands are ordinary array writes and pass through unchanged. A command whose first address byte has its most significant bit set is a security setup instead. It carries a starting block in its first byte and a block count in its second byte.

Once the bus side signals that the command has completed, the unit commits the new region. From that point, every array write address is compared against the region. A write into a protected block raises `prot_hit`, and its write enable is held low.

A small command parser state machine tracks each command. It has five states:

- `PS_IDLE`: no command is open.
- `PS_WAIT_HI`: waiting for the first address byte.
- `PS_WAIT_CNT`: a security command is open and waits for its count byte.
- `PS_ARMED`: both setup bytes are held and wait for the completion strobe.
- `PS_PASS`: an ordinary array write; its remaining bytes are ignored.

The transitions are as follows:

- The completion strobe takes every state to `PS_IDLE`. In `PS_ARMED` it also commits the region.
- Otherwise, a new-command strobe takes every state to `PS_WAIT_HI`.
- Otherwise, a byte received in `PS_WAIT_HI` leads to `PS_WAIT_CNT` when bit 7 is 1, and to `PS_PASS` when bit 7 is 0.
- Otherwise, a byte received in `PS_WAIT_CNT` leads to `PS_ARMED`.
- A byte received in `PS_ARMED` or `PS_PASS` is ignored.

Top module: `blkguard_top`

## Requirements
- R1: After reset, no block is protected: `prot_hit` is 0 and `wr_en_out` follows `wr_en_in` for every address.
- R2: A first address byte with bit 7 equal to 0 marks an ordinary array write. That command never changes the protected region.
- R3: In a security command, the starting block is taken from bits 3:0 of the first address byte. Bits 6:4 of that byte are ignored.
- R4: The block count is taken from bits 4:0 of the second address byte, as a value from 0 to 31. Bits 7:5 of that byte are ignored.
- R5: A committed count of zero turns protection off entirely.
- R6: A region that would extend past block 15 is clipped, so that it ends at block 15.
- R7: `prot_hit` is 1 exactly when protection is on and `chk_addr[12:9]` lies from the start block to the last block, inclusive. `wr_en_out` equals `wr_en_in` AND NOT `prot_hit`.
- R8: The region changes only on `cfg_done`, and only when both setup bytes have been received. Any of the following discards the pending setup and leaves the region unchanged:
  - `cfg_done` arriving before the count byte;
  - a new `cmd_start`.
- R9: Address bytes after the second byte of a security command are ignored.
- R10: When `cfg_done` and `cmd_start` are asserted in the same cycle, `cfg_done` takes priority. When `cmd_start` and `byte_vld` are asserted in the same cycle, `cmd_start` takes priority and the byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | One-cycle strobe that opens a new write command |
| byte_vld | input | 1 | One-cycle strobe that marks `byte_in` as an address byte |
| byte_in | input | 8 | Address byte value |
| cfg_done | input | 1 | Command-complete strobe |
| chk_addr | input | 13 | Array byte address to be checked |
| wr_en_in | input | 1 | Requested array write enable |
| prot_hit | output | 1 | The checked address is in the protected region |
| wr_en_out | output | 1 | Write enable after protection is applied |

## Verification
The assertions assume that `cmd_start`, `byte_vld` and `cfg_done` are single-cycle strobes sampled on the rising edge. They also assume that `chk_addr` is a plain 13-bit byte address with no undefined bits. The bench drives every strobe for exactly one cycle, changing it at the falling edge, and never leaves an input undefined. For every start block and for counts from 0 to 20 and 31, it sweeps all sixteen blocks. It also replays aborted, interrupted and ordinary commands, and checks that the region is unchanged after each of them.

// File: rtl/blkguard_pkg.sv
package blkguard_pkg;
    localparam int ADDR_W = 13;
    localparam int BLK_W  = 4;
    localparam int CNT_W  = 5;
    localparam int OFS_W  = ADDR_W - BLK_W;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_WAIT_HI,
        PS_WAIT_CNT,
        PS_ARMED,
        PS_PASS
    } pstate_t;
endpackage

// File: rtl/cmd_parser.sv
module cmd_parser
    import blkguard_pkg::*;
#(
    parameter int SBLK_W = BLK_W,
    parameter int SCNT_W = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic              cfg_done,
    output logic [SBLK_W-1:0] pend_start,
    output logic [SCNT_W-1:0] pend_count,
    output logic              commit
);
    pstate_t st, st_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= PS_IDLE;
        else        st <= st_nx;
    end

    // next-state logic: cfg_done beats cmd_start, which beats byte_vld (R10)
    always_comb begin
        st_nx = st;
        if (cfg_done) begin
            st_nx = PS_IDLE;
        end else if (cmd_start) begin
            st_nx = PS_WAIT_HI;
        end else if (byte_vld) begin
            unique case (st)
                PS_IDLE:     st_nx = PS_IDLE;
                PS_WAIT_HI:  st_nx = byte_in[7] ? PS_WAIT_CNT : PS_PASS;
                PS_WAIT_CNT: st_nx = PS_ARMED;
                PS_ARMED:    st_nx = PS_ARMED;
                PS_PASS:     st_nx = PS_PASS;
                default:     st_nx = PS_IDLE;
            endcase
        end
    end

    // captured setup bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_start <= '0;
            pend_count <= '0;
        end else if (byte_vld && !cmd_start && !cfg_done) begin
            if (st == PS_WAIT_HI && byte_in[7]) pend_start <= byte_in[SBLK_W-1:0]; // R3
            if (st == PS_WAIT_CNT)              pend_count <= byte_in[SCNT_W-1:0]; // R4
        end
    end

    // outputs
    always_comb begin
        commit = cfg_done && (st == PS_ARMED);
    end

    // R2: a first byte with bit 7 clear starts a plain array write
    assert_plain_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_WAIT_HI && byte_vld && !byte_in[7] && !cmd_start && !cfg_done)
            |=> (st == PS_PASS));

    // R9: once armed, further bytes do not move the state or the captured values
    assert_extra_bytes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_ARMED && !cmd_start && !cfg_done)
            |=> (st == PS_ARMED && $stable(pend_start) && $stable(pend_count)));
endmodule

// File: rtl/region_reg.sv
module region_reg
    import blkguard_pkg::*;
#(
    parameter int RBLK_W = BLK_W,
    parameter int RCNT_W = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [RBLK_W-1:0] pend_start,
    input  logic [RCNT_W-1:0] pend_count,
    output logic              reg_en,
    output logic [RBLK_W-1:0] reg_lo,
    output logic [RBLK_W-1:0] reg_hi
);
    localparam int SUM_W = ((RCNT_W > RBLK_W) ? RCNT_W : RBLK_W) + 1;
    localparam logic [SUM_W-1:0] TOP_BLK = SUM_W'((1 << RBLK_W) - 1);

    logic [SUM_W-1:0]  sum_end;
    logic [RBLK_W-1:0] hi_nx;

    always_comb begin
        sum_end = SUM_W'(pend_start) + SUM_W'(pend_count) - SUM_W'(1);
        hi_nx   = (sum_end > TOP_BLK) ? TOP_BLK[RBLK_W-1:0] : sum_end[RBLK_W-1:0]; // R6
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_en <= 1'b0;
            reg_lo <= '0;
            reg_hi <= '0;
        end else if (commit) begin
            reg_en <= (pend_count != '0); // R5
            reg_lo <= pend_start;
            reg_hi <= hi_nx;
        end
    end

    // R8: the region holds still without a commit
    assert_hold_without_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(reg_en) && $stable(reg_lo) && $stable(reg_hi)));

    // R6: an enabled region never wraps below its start
    assert_region_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_en |-> (reg_hi >= reg_lo));
endmodule

// File: rtl/addr_checker.sv
module addr_checker
    import blkguard_pkg::*;
#(
    parameter int CADDR_W = ADDR_W,
    parameter int CBLK_W  = BLK_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_en,
    input  logic [CBLK_W-1:0]  reg_lo,
    input  logic [CBLK_W-1:0]  reg_hi,
    input  logic [CADDR_W-1:0] chk_addr,
    output logic               hit
);
    logic [CBLK_W-1:0] blk;

    always_comb begin
        blk = chk_addr[CADDR_W-1 -: CBLK_W];
        hit = reg_en && (blk >= reg_lo) && (blk <= reg_hi); // R7
    end

    // R5: a disabled region protects nothing
    assert_off_no_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en |-> !hit);
endmodule

// File: rtl/blkguard_top.sv
module blkguard_top
    import blkguard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic              cfg_done,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic              wr_en_in,
    output logic              prot_hit,
    output logic              wr_en_out
);
    logic [BLK_W-1:0] pend_start, reg_lo, reg_hi;
    logic [CNT_W-1:0] pend_count;
    logic             commit, reg_en;

    cmd_parser #(.SBLK_W(BLK_W), .SCNT_W(CNT_W)) u_parser (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .byte_vld(byte_vld),
        .byte_in(byte_in), .cfg_done(cfg_done), .pend_start(pend_start),
        .pend_count(pend_count), .commit(commit)
    );

    region_reg #(.RBLK_W(BLK_W), .RCNT_W(CNT_W)) u_region (
        .clk(clk), .rst_n(rst_n), .commit(commit), .pend_start(pend_start),
        .pend_count(pend_count), .reg_en(reg_en), .reg_lo(reg_lo), .reg_hi(reg_hi)
    );

    addr_checker #(.CADDR_W(ADDR_W), .CBLK_W(BLK_W)) u_check (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_lo(reg_lo), .reg_hi(reg_hi),
        .chk_addr(chk_addr), .hit(prot_hit)
    );

    assign wr_en_out = wr_en_in & ~prot_hit;

    // R1: protection is off in the first cycle after reset
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> !prot_hit);
endmodule

// File: tb/tb_blkguard_top.sv
module tb_blkguard_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0, byte_vld = 1'b0, cfg_done = 1'b0, wr_en_in = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic [12:0] chk_addr = 13'h0;
    logic        prot_hit, wr_en_out;

    int total = 0, bad = 0;
    int cur_lo = 0, cur_hi = -1; // expected region, empty when hi < lo
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    blkguard_top dut (.*);

    task automatic pulse(input logic s, input logic b, input logic d, input logic [7:0] v);
        @(negedge clk);
        cmd_start = s; byte_vld = b; cfg_done = d; byte_in = v;
        @(negedge clk);
        cmd_start = 0; byte_vld = 0; cfg_done = 0; byte_in = 8'h00;
    endtask

    function automatic void set_exp(input int st, input int cnt);
        int last;
        last = st + cnt - 1;
        if (last > 15) last = 15;
        cur_lo = st;
        cur_hi = (cnt == 0) ? -1 : last;
    endfunction

    // sweep every block; the expected value follows from the model region
    task automatic sweep(input string tag);
        for (int b = 0; b < 16; b++) begin
            logic exp;
            chk_addr = 13'((b << 9) | ((b * 37 + 5) & 9'h1FF));
            wr_en_in = 1'b1;
            #1;
            exp = (b >= cur_lo) && (b <= cur_hi);
            total++;
            if (prot_hit !== exp || wr_en_out !== !exp) begin
                bad++;
                $display("FAIL %s blk=%0d prot=%b wr=%b expected prot=%b wr=%b",
                         tag, b, prot_hit, wr_en_out, exp, !exp);
            end
        end
        wr_en_in = 1'b0;
    endtask

    task automatic configure(input int st, input int cnt);
        pulse(1, 0, 0, 8'h00);
        pulse(0, 1, 0, 8'(8'h80 | 8'(st) | 8'h50)); // R3: bits 6:4 junk
        pulse(0, 1, 0, 8'(8'hA0 | 8'(cnt)));         // R4: bits 7:5 junk
        pulse(0, 0, 1, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sweep("R1 reset");

        // R3 R4 R5 R6 R7: exhaustive start sweep over many counts
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c <= 21; c++) begin
                int cc = (c == 21) ? 31 : c;
                configure(s, cc);
                set_exp(s, cc);
                sweep("R7 sweep");
            end
        end

        configure(4, 3); set_exp(4, 3); sweep("R7 base");

        // R2: ordinary write with address-like bytes
        pulse(1, 0, 0, 0); pulse(0, 1, 0, 8'h05); pulse(0, 1, 0, 8'h01); pulse(0, 0, 1, 0);
        sweep("R2 plain write");

        // R8: completion before the count byte
        pulse(1, 0, 0, 0); pulse(0, 1, 0, 8'h82); pulse(0, 0, 1, 0);
        sweep("R8 early done");

        // R8: new command discards a pending setup
        pulse(1, 0, 0, 0); pulse(0, 1, 0, 8'h81); pulse(0, 1, 0, 8'h02);
        pulse(1, 0, 0, 0); pulse(0, 0, 1, 0);
        sweep("R8 restart");

        // R9: extra bytes after the count byte are ignored
        pulse(1, 0, 0, 0); pulse(0, 1, 0, 8'h8A); pulse(0, 1, 0, 8'h02);
        pulse(0, 1, 0, 8'h8F); pulse(0, 1, 0, 8'h07); pulse(0, 0, 1, 0);
        set_exp(10, 2); sweep("R9 extra bytes");

        // R10: done and start together commits
        pulse(1, 0, 0, 0); pulse(0, 1, 0, 8'h81); pulse(0, 1, 0, 8'h01);
        pulse(1, 0, 1, 0);
        set_exp(1, 1); sweep("R10 done wins");

        // R10: start with a byte drops the byte, so next byte is the first
        pulse(0, 0, 1, 0);
        pulse(1, 1, 0, 8'h8C); pulse(0, 1, 0, 8'h83); pulse(0, 1, 0, 8'h02);
        pulse(0, 0, 1, 0);
        set_exp(3, 2); sweep("R10 start wins");

        // R1: reset clears an active region
        configure(0, 16); set_exp(0, 16); sweep("R6 full");
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        set_exp(0, 0); @(negedge clk); sweep("R1 re-reset");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule